// File: doc/BRIEF.md
# Decade Pulse-Rate Generator with Run/Stop/Step Control

This block sits at the front of a logic section and decides when that section's clocked elements may advance. It takes the 1 MHz machine clock, treated as a per-cycle enable domain. It produces a gated logic-clock enable and four strobe trains, one per decade. A cascade of modulo-10 counters advances only on enabled cycles and yields strobes at 100 kHz, 10 kHz, 1 kHz and 100 Hz. Each strobe is high for exactly one machine cycle once per period.

A small front-panel controller handles three press inputs. Each input is a single-cycle pulse, already synchronised and debounced. From clear, the controller can enter free-running mode, where every cycle is enabled, or stopped mode. In stopped mode each press of the step input lets exactly one enabled cycle through. A clear press raises a one-cycle global clear strobe and resets the divider. The divider is also reset whenever free-running mode is entered from another mode. It has a separate active-low clear input that holds it at zero.

Top module: `decade_pulse_gen`

## Requirements
- R1: While and after reset, mode_o reads clear (2'b00), and logic_en_o, pulse_o and clear_o are all zero.
- R2: A run press (with no clear press) puts mode_o at run (2'b01) from the next cycle, and logic_en_o is high in every cycle spent in run mode.
- R3: Entering run mode from clear or stop resets the divider, so pulse_o[0] first rises on the 10th enabled cycle after the press. A run press while already running does not reset the divider.
- R4: pulse_o[k] is high for one cycle on every 10^(k+1)-th enabled cycle. Bit 0 is 100 kHz, bit 1 is 10 kHz, bit 2 is 1 kHz and bit 3 is 100 Hz. No pulse occurs on a cycle where logic_en_o is low.
- R5: pulse_o[k] high implies pulse_o[k-1] high in the same cycle, for every k of 1 or more.
- R6: A step press in run mode moves mode_o to stop (2'b10), and logic_en_o is low from the next cycle.
- R7: In stop mode, each step press yields exactly one enabled cycle, in the cycle right after the press. Without a press, logic_en_o stays low.
- R8: A clear press produces clear_o high for exactly the next cycle, sets mode_o to clear, drops logic_en_o and resets the divider.
- R9: From clear mode, a step press enters stop mode without an enabled cycle, and a run press enters run mode.
- R10: While div_clr_ni is low, the divider is held at zero and pulse_o stays zero. After it returns high, pulse_o[0] next rises on the 10th enabled cycle.
- R11: Simultaneous presses resolve with clear over run, and run over step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1 MHz machine clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_press_i | input | 1 | Single-cycle run button press |
| step_press_i | input | 1 | Single-cycle stop/step button press |
| clr_press_i | input | 1 | Single-cycle clear button press |
| div_clr_ni | input | 1 | Divider clear, active low, level sensitive |
| logic_en_o | output | 1 | Gated clock enable for the logic elements |
| pulse_o | output | 4 | Decade strobes; bit 0 is 100 kHz through bit 3 at 100 Hz |
| clear_o | output | 1 | One-cycle global clear strobe |
| mode_o | output | 2 | Mode for lamp display: 00 clear, 01 run, 10 stop |

## Verification
A press is taken at a clock edge. mode_o, clear_o and the enable resulting from a step all change one cycle after the press. The strobes follow the divider state in the same cycle as the enable, so each strobe is due in the cycle that carries the 10^(k+1)-th enabled cycle since the last divider reset. The bench applies each stimulus just after a falling edge and samples 1 ns later. It counts enabled cycles in its own model and resets that count exactly where a clear press, a low div_clr_ni or an entry into run applies. Mode and clear results from the vector table are read one full cycle after the press.

// File: rtl/dpg_pkg.sv
`timescale 1ns/1ps
package dpg_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'b00,
    MODE_RUN   = 2'b01,
    MODE_STOP  = 2'b10
  } mode_e;
endpackage

// File: rtl/dpg_mode_ctrl.sv
`timescale 1ns/1ps
module dpg_mode_ctrl
  import dpg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_press_i,
  input  logic  step_press_i,
  input  logic  clr_press_i,
  output logic  en_o,
  output logic  clear_o,
  output logic  div_reset_o,
  output mode_e mode_o
);

  mode_e mode_q, mode_d;
  logic  step_q, step_d;
  logic  clear_q, clear_d;

  // priority: clear > run > step
  always_comb begin
    mode_d  = mode_q;
    step_d  = 1'b0;
    clear_d = 1'b0;
    if (clr_press_i) begin
      mode_d  = MODE_CLEAR;
      clear_d = 1'b1;
    end else if (run_press_i) begin
      mode_d = MODE_RUN;
    end else if (step_press_i) begin
      unique case (mode_q)
        MODE_RUN:   mode_d = MODE_STOP;
        MODE_STOP:  step_d = 1'b1;
        MODE_CLEAR: mode_d = MODE_STOP;
        default:    mode_d = MODE_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_CLEAR;
      step_q  <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      step_q  <= step_d;
      clear_q <= clear_d;
    end
  end

  assign en_o        = (mode_q == MODE_RUN) | step_q;
  assign clear_o     = clear_q;
  assign mode_o      = mode_q;
  // divider restarts on clear and on entry into run
  assign div_reset_o = clr_press_i | (run_press_i & (mode_q != MODE_RUN));

  AST_RUN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_press_i && !clr_press_i |=> mode_q == MODE_RUN && en_o); // R2
  AST_RUN_TO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_RUN && step_press_i && !run_press_i && !clr_press_i
    |=> mode_q == MODE_STOP && !en_o); // R6
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_STOP && step_press_i && !run_press_i && !clr_press_i |=> en_o); // R7
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != MODE_RUN && !step_press_i && !run_press_i |=> !en_o); // R7
  AST_CLR_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_press_i |=> clear_o && mode_q == MODE_CLEAR && !en_o); // R8
  AST_CLR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_press_i |=> !clear_o); // R8
  AST_CLEAR_TO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_CLEAR && step_press_i && !run_press_i && !clr_press_i
    |=> mode_q == MODE_STOP && !en_o); // R9

endmodule

// File: rtl/dpg_decade_stage.sv
`timescale 1ns/1ps
module dpg_decade_stage #(
  parameter int unsigned RADIX = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic wrap_o
);

  localparam int unsigned CntW = (RADIX > 1) ? $clog2(RADIX) : 1;
  localparam logic [CntW-1:0] Last = CntW'(RADIX - 1);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= (cnt_q == Last) ? '0 : cnt_q + CntW'(1);
    end
  end

  assign wrap_o = (cnt_q == Last);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= Last); // R4
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R10

endmodule

// File: rtl/dpg_divider.sv
`timescale 1ns/1ps
module dpg_divider #(
  parameter int unsigned NUM_DECADES = 4,
  parameter int unsigned RADIX       = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   en_i,
  input  logic                   pass_i,
  output logic [NUM_DECADES-1:0] strobe_o
);

  logic [NUM_DECADES:0]   carry;
  logic [NUM_DECADES-1:0] wrap;

  assign carry[0] = en_i;

  for (genvar k = 0; k < NUM_DECADES; k++) begin : g_stage
    dpg_decade_stage #(.RADIX(RADIX)) i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .adv_i  (carry[k]),
      .wrap_o (wrap[k])
    );
    assign carry[k+1] = carry[k] & wrap[k];
    assign strobe_o[k] = carry[k+1] & pass_i;

    if (k > 0) begin : g_nest
      AST_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o[k] |-> strobe_o[k-1]); // R5
    end
  end

  AST_STROBE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |strobe_o |-> en_i); // R4
  AST_HELD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_i |-> strobe_o == '0); // R10

endmodule

// File: rtl/decade_pulse_gen.sv
`timescale 1ns/1ps
module decade_pulse_gen
  import dpg_pkg::*;
#(
  parameter int unsigned NUM_DECADES = 4,
  parameter int unsigned RADIX       = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_press_i,
  input  logic                   step_press_i,
  input  logic                   clr_press_i,
  input  logic                   div_clr_ni,
  output logic                   logic_en_o,
  output logic [NUM_DECADES-1:0] pulse_o,
  output logic                   clear_o,
  output logic [1:0]             mode_o
);

  mode_e mode;
  logic  en;
  logic  ctrl_div_reset;
  logic  div_clr;

  dpg_mode_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_press_i  (run_press_i),
    .step_press_i (step_press_i),
    .clr_press_i  (clr_press_i),
    .en_o         (en),
    .clear_o      (clear_o),
    .div_reset_o  (ctrl_div_reset),
    .mode_o       (mode)
  );

  assign div_clr = ctrl_div_reset | ~div_clr_ni;

  dpg_divider #(
    .NUM_DECADES (NUM_DECADES),
    .RADIX       (RADIX)
  ) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (div_clr),
    .en_i     (en),
    .pass_i   (div_clr_ni),
    .strobe_o (pulse_o)
  );

  assign logic_en_o = en;
  assign mode_o     = mode;

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11); // R1
  AST_RUN_ALL_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b01 |-> logic_en_o); // R2

endmodule

// File: tb/test_decade_pulse_gen.sv
`timescale 1ns/1ps
module test_decade_pulse_gen;

  localparam int ND = 4;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run_p = 1'b0, step_p = 1'b0, clr_p = 1'b0, dclr_n = 1'b1;
  logic          logic_en;
  logic [ND-1:0] pulse;
  logic          clear;
  logic [1:0]    mode;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // model state
  int  n_en      = 0;   // enabled cycles since divider reset
  bit  exp_run   = 1'b0;
  int  en_seen   = 0;
  bit  pulse_err_shown = 1'b0;

  always #10 clk = ~clk;

  decade_pulse_gen i_decade_pulse_gen (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .run_press_i  (run_p),
    .step_press_i (step_p),
    .clr_press_i  (clr_p),
    .div_clr_ni   (dclr_n),
    .logic_en_o   (logic_en),
    .pulse_o      (pulse),
    .clear_o      (clear),
    .mode_o       (mode)
  );

  // {run, step, clr, exp_en, exp_mode[1:0], exp_clear}
  localparam logic [6:0] VEC [NV] = '{
    7'b000_0_00_0,  // idle in clear         R1
    7'b010_0_10_0,  // step from clear       R9
    7'b010_1_10_0,  // step in stop          R7
    7'b000_0_10_0,  // stop idle             R7
    7'b100_1_01_0,  // run                   R2
    7'b000_1_01_0,  // stays running         R2
    7'b010_0_10_0,  // step in run -> stop   R6
    7'b001_0_00_1,  // clear press           R8
    7'b000_0_00_0,  // strobe is single      R8
    7'b111_0_00_1,  // all three             R11
    7'b110_1_01_0,  // run beats step        R11
    7'b011_0_00_1,  // clear beats step      R11
    7'b100_1_01_0,  // run from clear        R9
    7'b001_0_00_1   // back to clear         R8
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1";
      1, 12: return "R9";
      2, 3: return "R7";
      4, 5: return "R2";
      6: return "R6";
      7, 8, 13: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // apply stimulus just after a falling edge, sample 1 ns later, advance
  task automatic tick(input bit r, input bit s, input bit c, input bit d, input string tag);
    int pw;
    logic [ND-1:0] exp_p;
    run_p = r; step_p = s; clr_p = c; dclr_n = d;
    #1;
    if (logic_en) begin
      n_en++;
      en_seen++;
    end
    pw = 1;
    for (int k = 0; k < ND; k++) begin
      pw = pw * 10;
      exp_p[k] = logic_en && d && (n_en % pw == 0) && (n_en > 0);
    end
    tests++;
    if (pulse !== exp_p) begin
      fails++;
      if (!pulse_err_shown)
        $display("FAIL %s pulse: actual %b expected %b at enabled cycle %0d", tag, pulse, exp_p, n_en);
      pulse_err_shown = 1'b1;
    end
    if (c || !d || (r && !exp_run)) n_en = 0;
    if (c) exp_run = 1'b0;
    else if (r) exp_run = 1'b1;
    else if (s) exp_run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int steps;
    int en_before;
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    check("R1 mode in reset", mode, 0);
    check("R1 enable in reset", logic_en, 0);
    check("R1 pulses in reset", pulse, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 mode after reset", mode, 0);
    check("R1 clear after reset", clear, 0);
    check("R1 enable after reset", logic_en, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][6], VEC[i][5], VEC[i][4], 1'b1, vec_tag(i));
      check({vec_tag(i), " table enable"}, logic_en, VEC[i][3]);
      check({vec_tag(i), " table mode"}, mode, VEC[i][2:1]);
      check({vec_tag(i), " table clear"}, clear, VEC[i][0]);
      run_p = 0; step_p = 0; clr_p = 0;
    end

    // long run from clear: decade timing R3 R4 R5
    tick(1, 0, 0, 1, "R3");
    for (int i = 0; i < 10050; i++) tick(0, 0, 0, 1, "R4");
    check("R2 mode running", mode, 1);

    // run press while running must not restart the divider
    tick(1, 0, 0, 1, "R3");
    for (int i = 0; i < 40; i++) tick(0, 0, 0, 1, "R3");

    // stop, then single steps
    tick(0, 1, 0, 1, "R6");
    check("R6 stopped", mode, 2);
    check("R6 enable low", logic_en, 0);
    en_before = en_seen;
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 1, "R7");
    check("R7 no enable idle", en_seen - en_before, 0);
    steps = 23;
    for (int i = 0; i < steps; i++) begin
      tick(0, 1, 0, 1, "R7");
      tick(0, 0, 0, 1, "R7");
    end
    check("R7 one enable per step", en_seen - en_before, steps);

    // back to run (entry resets divider), then divider clear held low
    tick(1, 0, 0, 1, "R3");
    for (int i = 0; i < 37; i++) tick(0, 0, 0, 1, "R3");
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 0, "R10");
    check("R10 no pulses held", pulse, 0);
    for (int i = 0; i < 130; i++) tick(0, 0, 0, 1, "R10");

    // clear during run
    tick(0, 0, 1, 1, "R8");
    check("R8 clear strobe", clear, 1);
    check("R8 enable dropped", logic_en, 0);
    tick(0, 0, 0, 1, "R8");
    check("R8 strobe ends", clear, 0);
    tick(1, 0, 0, 1, "R9");
    check("R9 run from clear", mode, 1);
    for (int i = 0; i < 120; i++) tick(0, 0, 0, 1, "R4");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule